// File: doc/BRIEF.md
# Fuse Mirror Loader

This block keeps a bank of byte-wide mirror registers that hold a copy of a 96-bit one-time-programmable fuse array. These are twelve bytes of trim, configuration and serial-number data. When reset is released the block powers the fuse array up and waits a fixed settle time. It then copies the array into the mirror one byte per clock and switches the array off again. The rest of the chip reads configuration from the mirror and never from the fuses.

A simple register port serves reads and writes over a 16-address byte map. A read returns its data one cycle later with a valid strobe. Writes land in the mirror only while test mode is asserted, and they last only until the next reload. A restore command runs the same power-up, settle and copy sequence again. This overwrites any values written in test mode. A busy flag stays high for the whole load. While busy is high, reads return nothing and further restore commands are dropped.

Top module: `otp_mirror_loader`

## Requirements
- R1: After reset is released the block loads all 12 fuse bytes without any command. `busy` is high for exactly SETTLE_CYCLES+12 cycles, then each mirror address 0..11 other than 5 reads back the fuse byte at the same index.
- R2: `arr_pwr_en` is high throughout a load and low whenever `busy` is low. `arr_addr` stays below 12 while the array is powered.
- R3: With `busy` low, a `reg_rd` sampled at a clock edge gives `reg_rvalid`=1 and the data on `reg_rdata` in the following cycle. Repeated reads of an address return the same value. When `reg_rvalid` is 0, `reg_rdata` is 0.
- R4: A `reg_wr` with `test_mode`=1 stores `reg_wdata` at a storable address. With `test_mode`=0 the write leaves every register unchanged.
- R5: A `restore_req` taken while idle reloads every mirror register from the array and overwrites test-mode writes. `busy` falls SETTLE_CYCLES+13 cycles after the command is driven.
- R6: A fuse image with no programmed bits reads back as 0 at every address after a load.
- R7: Addresses 0..3 hold the 32-bit serial number, least significant byte at address 0.
- R8: Address 5 is reserved. It always reads 0, even when fuse byte 5 is nonzero or a test-mode write targets it.
- R9: A read issued while `busy` is high gives `reg_rvalid`=0 and `reg_rdata`=0.
- R10: A `restore_req` that arrives while `busy` is high is ignored, so the running load keeps its original length.
- R11: Addresses 12..15 read 0 with `reg_rvalid`=1, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Allows mirror writes when high |
| restore_req | input | 1 | Reload mirror from the fuse array |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid strobe |
| busy | output | 1 | Load or restore in progress |
| arr_pwr_en | output | 1 | Fuse array power enable |
| arr_addr | output | 4 | Fuse array byte address |
| arr_rdata | input | 8 | Fuse array read data |

## Verification
The assertions run on every cycle and cover the relations between the status and bus signals. They check that array power follows busy and that the array address stays inside the fuse range. They also check that a valid strobe only ever answers an idle read, that data is zero outside a valid strobe and at the reserved address, and that a restore during a load never cuts busy short. Only the bench's scenarios can show the contents of the mirror. These scenarios are full address sweeps after the automatic load, after test-mode and normal-mode writes, and after restores from two fuse images. They also cover the exact load lengths and the serial-number byte order.

// File: rtl/otp_mirror_pkg.sv
package otp_mirror_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int RSVD_ADDR = 5;

    typedef enum logic [1:0] {
        LD_SETTLE = 2'd0,
        LD_READ   = 2'd1,
        LD_IDLE   = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic is_storable(logic [ADDR_W-1:0] a, int unsigned nbytes);
        return (int'(a) < int'(nbytes)) && (int'(a) != RSVD_ADDR);
    endfunction

endpackage

// File: rtl/otp_load_seq.sv
module otp_load_seq
    import otp_mirror_pkg::*;
#(
    parameter int NUM_BYTES     = 12,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              pwr_en,
    output logic              store_en,
    output logic [ADDR_W-1:0] rd_idx
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(NUM_BYTES - 1);

    ld_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_SETTLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                LD_IDLE: begin
                    if (start) begin
                        state <= LD_SETTLE;
                        cnt   <= '0;
                        idx   <= '0;
                    end
                end
                LD_SETTLE: begin
                    if (cnt == CNT_LAST) state <= LD_READ;
                    else                 cnt   <= cnt + 1'b1;
                end
                LD_READ: begin
                    if (idx == IDX_LAST) state <= LD_IDLE;
                    else                 idx   <= idx + 1'b1;
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    assign busy     = (state != LD_IDLE);
    assign pwr_en   = busy;
    assign store_en = (state == LD_READ);
    assign rd_idx   = idx;
endmodule

// File: rtl/otp_mirror_bank.sv
module otp_mirror_bank
    import otp_mirror_pkg::*;
#(
    parameter int NUM_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] q [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        if (g == RSVD_ADDR) begin : g_rsvd
            assign q[g] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)                                   r <= '0;
                else if (ld_en && ld_idx == ADDR_W'(g))    r <= ld_data;
                else if (wr_en && wr_idx == ADDR_W'(g))    r <= wr_data;
            end
            assign q[g] = r;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_idx == ADDR_W'(i)) rd_data = q[i];
        end
    end
endmodule

// File: rtl/otp_reg_port.sv
module otp_reg_port
    import otp_mirror_pkg::*;
#(
    parameter int NUM_BYTES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              test_mode,
    input  logic              busy,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic rd_ok;

    assign rd_ok = req.rd && !busy;
    assign wr_en = req.wr && test_mode && !busy && is_storable(req.addr, NUM_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_ok;
            rdata  <= rd_ok ? bank_rdata : '0;
        end
    end
endmodule

// File: rtl/otp_mirror_loader.sv
module otp_mirror_loader
    import otp_mirror_pkg::*;
#(
    parameter int NUM_BYTES     = 12,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_mode,
    input  logic              restore_req,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              busy,
    output logic              arr_pwr_en,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata
);
    reg_req_t          req;
    logic              store_en;
    logic              wr_en;
    logic [ADDR_W-1:0] ld_idx;
    logic [DATA_W-1:0] bank_rdata;

    assign req = '{rd: reg_rd, wr: reg_wr, addr: reg_addr, wdata: reg_wdata};

    otp_load_seq #(
        .NUM_BYTES    (NUM_BYTES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (restore_req),
        .busy    (busy),
        .pwr_en  (arr_pwr_en),
        .store_en(store_en),
        .rd_idx  (ld_idx)
    );

    assign arr_addr = ld_idx;

    otp_mirror_bank #(.NUM_BYTES(NUM_BYTES)) bank_i (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (store_en),
        .ld_idx (ld_idx),
        .ld_data(arr_rdata),
        .wr_en  (wr_en),
        .wr_idx (req.addr),
        .wr_data(req.wdata),
        .rd_idx (req.addr),
        .rd_data(bank_rdata)
    );

    otp_reg_port #(.NUM_BYTES(NUM_BYTES)) port_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .test_mode (test_mode),
        .busy      (busy),
        .bank_rdata(bank_rdata),
        .wr_en     (wr_en),
        .rdata     (reg_rdata),
        .rvalid    (reg_rvalid)
    );
endmodule

// File: rtl/otp_mirror_chk.sv
module otp_mirror_chk
    import otp_mirror_pkg::*;
#(
    parameter int NUM_BYTES = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              restore_req,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_rvalid,
    input logic              busy,
    input logic              arr_pwr_en,
    input logic [ADDR_W-1:0] arr_addr
);
    // R2
    pwr_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_pwr_en == busy);

    // R2
    arr_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        arr_pwr_en |-> (int'(arr_addr) < NUM_BYTES));

    // R9
    rvalid_needs_idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rvalid |-> $past(reg_rd && !busy));

    // R3
    rdata_zero_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rvalid |-> (reg_rdata == '0));

    // R8
    reserved_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rvalid && $past(reg_addr) == ADDR_W'(RSVD_ADDR)) |-> (reg_rdata == '0));

    // R10
    restore_in_load_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && restore_req && int'(arr_addr) < NUM_BYTES - 1) |=> busy);
endmodule

bind otp_mirror_loader otp_mirror_chk #(.NUM_BYTES(NUM_BYTES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .restore_req(restore_req),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .busy       (busy),
    .arr_pwr_en (arr_pwr_en),
    .arr_addr   (arr_addr)
);

// File: tb/otp_mirror_loader_tb_top.sv
module otp_mirror_loader_tb_top;
    localparam int NB = 12;
    localparam int SC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_mode = 1'b0;
    logic       restore_req = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       reg_rvalid;
    logic       busy;
    logic       arr_pwr_en;
    logic [3:0] arr_addr;
    logic [7:0] arr_rdata;

    int image_sel = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] fuse_byte(int sel, int i);
        if (sel != 0) return 8'h00;
        return 8'((i * 37 + 11) & 255);
    endfunction

    // behavioural fuse array: garbage when unpowered
    always_comb begin
        if (!arr_pwr_en)           arr_rdata = 8'hA5;
        else if (int'(arr_addr) < NB) arr_rdata = fuse_byte(image_sel, int'(arr_addr));
        else                       arr_rdata = 8'h00;
    end

    otp_mirror_loader #(.NUM_BYTES(NB), .SETTLE_CYCLES(SC)) dut_i (
        .clk(clk), .rst(rst), .test_mode(test_mode), .restore_req(restore_req),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .busy(busy),
        .arr_pwr_en(arr_pwr_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mirror_exp(int sel, int a);
        if (a >= NB || a == 5) return 8'h00;
        return fuse_byte(sel, a);
    endfunction

    task automatic do_read(input int a, output logic [7:0] d, output logic v);
        reg_rd = 1'b1; reg_addr = 4'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata; v = reg_rvalid;
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input logic tm);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d; test_mode = tm;
        @(negedge clk);
        reg_wr = 1'b0; test_mode = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (cnt < 1000) begin
            @(negedge clk);
            cnt++;
            if (!busy) break;
        end
    endtask

    task automatic sweep_check(input int sel, input string req);
        logic [7:0] d; logic v;
        for (int a = 0; a < 16; a++) begin
            do_read(a, d, v);
            check(v == 1'b1, req, int'(v), 1);
            check(d == mirror_exp(sel, a), req, int'(d), int'(mirror_exp(sel, a)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [7:0] d;
        logic v;
        logic [31:0] sn;

        repeat (3) @(negedge clk);
        // reset state
        check(busy == 1'b1 && arr_pwr_en == 1'b1, "R2 reset", int'({busy, arr_pwr_en}), 3);
        check(reg_rvalid == 1'b0 && reg_rdata == 8'h00, "R3 reset", int'(reg_rdata), 0);
        rst = 1'b0;

        // R1: automatic load length
        wait_idle(cnt);
        check(cnt == SC + NB, "R1 load length", cnt, SC + NB);
        check(arr_pwr_en == 1'b0, "R2 power off after load", int'(arr_pwr_en), 0);

        // R1, R8, R11: full sweep after load
        sweep_check(0, "R1 R8 R11 post-load sweep");
        // R3: static, repeated read
        sweep_check(0, "R3 repeat sweep");

        // R7: serial number, LSB first
        sn = '0;
        for (int a = 0; a < 4; a++) begin
            do_read(a, d, v);
            sn[a*8 +: 8] = d;
        end
        check(sn == {fuse_byte(0, 3), fuse_byte(0, 2), fuse_byte(0, 1), fuse_byte(0, 0)},
              "R7 serial", int'(sn), int'({fuse_byte(0, 3), fuse_byte(0, 2), fuse_byte(0, 1), fuse_byte(0, 0)}));

        // R4: writes without test mode ignored
        for (int a = 0; a < 16; a++) do_write(a, 8'(~a), 1'b0);
        sweep_check(0, "R4 non-test writes ignored");

        // R4, R8, R11: test-mode writes
        for (int a = 0; a < 16; a++) do_write(a, 8'(8'hC0 | a), 1'b1);
        for (int a = 0; a < 16; a++) begin
            logic [7:0] e;
            e = (a < NB && a != 5) ? 8'(8'hC0 | a) : 8'h00;
            do_read(a, d, v);
            check(v == 1'b1 && d == e, "R4 R8 R11 test write", int'(d), int'(e));
        end

        // R5: restore overwrites test writes
        restore_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0;
        check(busy == 1'b1, "R5 restore starts", int'(busy), 1);
        wait_idle(cnt);
        check(cnt + 1 == SC + NB + 1, "R5 restore length", cnt + 1, SC + NB + 1);
        sweep_check(0, "R5 restored sweep");

        // R9, R10: read and restore during load, then R6 with blank image
        image_sel = 1;
        restore_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0;
        do_read(2, d, v);
        check(v == 1'b0 && d == 8'h00, "R9 read while busy", int'({v, d}), 0);
        restore_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0;
        wait_idle(cnt);
        check(cnt + 3 == SC + NB + 1, "R10 restore while busy ignored", cnt + 3, SC + NB + 1);
        check(arr_pwr_en == 1'b0, "R2 power off after restore", int'(arr_pwr_en), 0);
        sweep_check(1, "R6 blank image reads zero");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule